// File: doc/BRIEF.md
# I2C Target with Four-Way Strapped Address

This block is an I2C-compatible target that gives a bus master read and write access to an on-chip register space. Each byte the master writes reaches that space as a one-cycle write strobe. Each byte the master reads is fetched through a one-cycle read strobe with the data returned in the same cycle.

The block oversamples SCL and SDA on its own clock through a synchronizer of configurable depth. It recognises START, repeated START and STOP, and it detects bits on SCL rising edges. It changes SDA only while SCL is low.

The 7-bit target address is not a binary field. It comes from two select pins, and each pin can be tied to ground, to supply, to SCL or to SDA. A pin counts as tied to a bus line only when it has tracked that line across several transitions with no disagreement. Otherwise the pin's steady level is used. The 16 combinations map to 16 addresses in the range 0x60 to 0x6F, through an irregular table.

Top module: `i2c_strap_target`

## Requirements
- R1: Each select pin is classified as ground (code 0), supply (1), SCL (2) or SDA (3). A pin that follows a bus line with no mismatch for at least FOLLOW_MIN transitions of that line counts as tied to that line. A pin that does not counts as its steady level. Once a pin is classified as tied to a line, it stays so until reset.
- R2: With idx = 4*hi_code + lo_code, and with the indices 0 and 12 swapped, the 8-bit write address is 0xC0 + 2*idx. For example, (ground, ground) gives 0xD8 and (SDA, ground) gives 0xC0.
- R3: A falling SDA while SCL is high is a START. It restarts address matching in any state, which includes a repeated START inside a transfer.
- R4: A rising SDA while SCL is high is a STOP. It releases SDA and returns the block to idle. Clock pulses that follow with no START get no acknowledge and have no effect.
- R5: After the first byte, the block pulls SDA low through the ninth clock when bits 7..1 equal its address. When they do not, it leaves SDA released and ignores the rest of the transfer, so no write strobe occurs.
- R6: Bit 0 of the address byte selects the direction: 1 means read and 0 means write. The read address is the write address with bit 0 set.
- R7: In a write, the byte after the address sets the register pointer. Each later byte is acknowledged and issued once on rp_wr, with rp_addr equal to the pointer and rp_wdata equal to the byte.
- R8: In a read, the byte at the pointer is sent MSB first. Each bit is placed while SCL is low and held while SCL is high.
- R9: In a read, an acknowledge from the master (SDA low on the ninth clock) fetches the next byte. A not-acknowledge releases SDA and ends the fetching.
- R10: The register pointer advances by one, wrapping modulo 256, after every rp_wr strobe and every rp_rd strobe.
- R11: Reset leaves SDA released and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| sel_hi_in | input | 1 | Upper address select pin |
| sel_lo_in | input | 1 | Lower address select pin |
| rp_addr | output | 8 | Register pointer |
| rp_wdata | output | 8 | Write data |
| rp_wr | output | 1 | Write strobe, one cycle |
| rp_rd | output | 1 | Read strobe, one cycle; data sampled the same cycle |
| rp_rdata | input | 8 | Read data for rp_addr |

## Verification
Most faults in this block surface at the master within one byte time. A wrong strap class or a wrong entry in the address table turns the address acknowledge into a not-acknowledge on the ninth clock of the first byte. A pointer that fails to load or advance shows up as a wrong register written, or as a wrong byte read back in the next transaction. A sequencer that loses its bit count returns shifted read data, or holds SDA low past the ninth clock. That stuck SDA is visible on the next sample of the line while SCL is low. Sweeping all sixteen strap combinations exposes every entry of the address table.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    STRAP_GND = 2'd0,
    STRAP_VDD = 2'd1,
    STRAP_SCL = 2'd2,
    STRAP_SDA = 2'd3
  } strap_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_PARK
  } tgt_state_e;

  // 7-bit target address chosen by the two strap classes
  function automatic logic [6:0] strap_to_addr(strap_e hi, strap_e lo);
    logic [6:0] a;
    unique case ({hi, lo})
      4'h0: a = 7'h6C;
      4'h1: a = 7'h61;
      4'h2: a = 7'h62;
      4'h3: a = 7'h63;
      4'h4: a = 7'h64;
      4'h5: a = 7'h65;
      4'h6: a = 7'h66;
      4'h7: a = 7'h67;
      4'h8: a = 7'h68;
      4'h9: a = 7'h69;
      4'hA: a = 7'h6A;
      4'hB: a = 7'h6B;
      4'hC: a = 7'h60;
      4'hD: a = 7'h6D;
      4'hE: a = 7'h6E;
      default: a = 7'h6F;
    endcase
    return a;
  endfunction

  function automatic logic [BYTE_W-1:0] ptr_next(logic [BYTE_W-1:0] p);
    return p + {{(BYTE_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  for (genvar g = 0; g < W; g++) begin : g_line
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = pipe[STAGES-1];
    assign prev[g] = pipe[STAGES];
  end

endmodule

// File: rtl/i2c_strap_classifier.sv
module i2c_strap_classifier
  import i2c_tgt_pkg::*;
#(
  parameter int FOLLOW_MIN = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_cur,
  input  logic   pin_prev,
  input  logic   scl_cur,
  input  logic   scl_prev,
  input  logic   sda_cur,
  input  logic   sda_prev,
  output strap_e kind
);

  localparam int CNT_W = $clog2(FOLLOW_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FOLLOW_MIN);

  logic             miss_scl, miss_sda;
  logic [CNT_W-1:0] cnt_scl, cnt_sda;
  logic             pin_steady;

  assign pin_steady = (pin_cur == pin_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_scl <= 1'b0;
      miss_sda <= 1'b0;
      cnt_scl  <= '0;
      cnt_sda  <= '0;
    end else begin
      // disagreement only counts when both signals have settled
      if (pin_steady && (scl_cur == scl_prev) && (pin_cur != scl_cur)) miss_scl <= 1'b1;
      if (pin_steady && (sda_cur == sda_prev) && (pin_cur != sda_cur)) miss_sda <= 1'b1;
      if ((scl_cur != scl_prev) && (cnt_scl != CNT_TOP)) cnt_scl <= cnt_scl + 1'b1;
      if ((sda_cur != sda_prev) && (cnt_sda != CNT_TOP)) cnt_sda <= cnt_sda + 1'b1;
    end
  end

  always_comb begin
    if (!miss_scl && cnt_scl == CNT_TOP)      kind = STRAP_SCL;
    else if (!miss_sda && cnt_sda == CNT_TOP) kind = STRAP_SDA;
    else if (pin_cur)                         kind = STRAP_VDD;
    else                                      kind = STRAP_GND;
  end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_cur,
  input  logic [6:0]        my_addr,
  input  logic [BYTE_W-1:0] rp_rdata,
  output logic              sda_drive_low,
  output logic [BYTE_W-1:0] rp_addr,
  output logic [BYTE_W-1:0] rp_wdata,
  output logic              rp_wr,
  output logic              rp_rd,
  output logic              addr_hit,
  output tgt_state_e        state
);

  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;
  logic              rw_q, mack_q, drive_q;
  logic              byte_full, rx_state;

  assign byte_full = (bitcnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == my_addr);
  assign rx_state  = (state == ST_ADDR) || (state == ST_REG) || (state == ST_WDATA);

  assign rp_wr = scl_fall && (state == ST_WDATA) && byte_full;
  assign rp_rd = scl_fall && (((state == ST_ADDR_ACK) && rw_q) ||
                              ((state == ST_RACK) && mack_q));

  assign rp_addr       = ptr;
  assign rp_wdata      = shreg;
  assign sda_drive_low = drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      drive_q <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      drive_q <= 1'b0;
    end else begin
      if (rx_state && scl_rise && !byte_full) begin
        shreg  <= {shreg[6:0], sda_cur};
        bitcnt <= bitcnt + 4'd1;
      end
      unique case (state)
        ST_ADDR: if (scl_fall && byte_full) begin
          if (addr_hit) begin
            drive_q <= 1'b1;
            rw_q    <= shreg[0];
            state   <= ST_ADDR_ACK;
          end else begin
            state   <= ST_PARK;
          end
        end
        ST_REG: if (scl_fall && byte_full) begin
          ptr     <= shreg;
          drive_q <= 1'b1;
          state   <= ST_REG_ACK;
        end
        ST_WDATA: if (scl_fall && byte_full) begin
          ptr     <= ptr_next(ptr);
          drive_q <= 1'b1;
          state   <= ST_WACK;
        end
        ST_ADDR_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw_q) begin
            shreg   <= rp_rdata;
            drive_q <= ~rp_rdata[7];
            ptr     <= ptr_next(ptr);
            state   <= ST_RDATA;
          end else begin
            drive_q <= 1'b0;
            state   <= ST_REG;
          end
        end
        ST_REG_ACK, ST_WACK: if (scl_fall) begin
          drive_q <= 1'b0;
          bitcnt  <= '0;
          state   <= ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (byte_full) begin
              drive_q <= 1'b0;
              state   <= ST_RACK;
            end else if (bitcnt != 4'd0) begin
              shreg   <= {shreg[6:0], 1'b0};
              drive_q <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_cur;
          if (scl_fall) begin
            bitcnt <= '0;
            if (mack_q) begin
              shreg   <= rp_rdata;
              drive_q <= ~rp_rdata[7];
              ptr     <= ptr_next(ptr);
              state   <= ST_RDATA;
            end else begin
              state   <= ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int FOLLOW_MIN  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic       sel_hi_in,
  input  logic       sel_lo_in,
  output logic [7:0] rp_addr,
  output logic [7:0] rp_wdata,
  output logic       rp_wr,
  output logic       rp_rd,
  input  logic [7:0] rp_rdata
);

  localparam int NLINES = 4;
  localparam int NSTRAP = 2;

  logic [NLINES-1:0] ln_cur, ln_prev;
  logic              scl_cur, scl_prev, sda_cur, sda_prev;
  logic              start_evt, stop_evt, scl_rise, scl_fall, addr_hit;
  strap_e            kinds [NSTRAP];
  strap_e            kind_hi, kind_lo;
  logic [6:0]        my_addr;
  tgt_state_e        eng_state;

  i2c_line_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({sel_hi_in, sel_lo_in, sda_in, scl_in}),
    .cur  (ln_cur),
    .prev (ln_prev)
  );

  assign scl_cur  = ln_cur[0];
  assign scl_prev = ln_prev[0];
  assign sda_cur  = ln_cur[1];
  assign sda_prev = ln_prev[1];

  assign start_evt = scl_cur && scl_prev && sda_prev && !sda_cur;
  assign stop_evt  = scl_cur && scl_prev && !sda_prev && sda_cur;
  assign scl_rise  = scl_cur && !scl_prev;
  assign scl_fall  = !scl_cur && scl_prev;

  // strap 0 is the lower select pin (line 2), strap 1 the upper (line 3)
  for (genvar s = 0; s < NSTRAP; s++) begin : g_strap
    i2c_strap_classifier #(.FOLLOW_MIN(FOLLOW_MIN)) u_cls (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_cur (ln_cur[2+s]),
      .pin_prev(ln_prev[2+s]),
      .scl_cur (scl_cur),
      .scl_prev(scl_prev),
      .sda_cur (sda_cur),
      .sda_prev(sda_prev),
      .kind    (kinds[s])
    );
  end

  assign kind_lo = kinds[0];
  assign kind_hi = kinds[1];
  assign my_addr = strap_to_addr(kind_hi, kind_lo);

  i2c_tgt_engine u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_cur      (sda_cur),
    .my_addr      (my_addr),
    .rp_rdata     (rp_rdata),
    .sda_drive_low(sda_drive_low),
    .rp_addr      (rp_addr),
    .rp_wdata     (rp_wdata),
    .rp_wr        (rp_wr),
    .rp_rd        (rp_rd),
    .addr_hit     (addr_hit),
    .state        (eng_state)
  );

endmodule

module i2c_strap_target_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_hi,
  input logic       sda_drive_low,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       rp_wr,
  input logic       rp_rd,
  input logic [7:0] rp_addr,
  input tgt_state_e state,
  input strap_e     kind_hi,
  input strap_e     kind_lo
);

  // R8
  sda_moves_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_hi);

  // R10
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_wr |=> rp_addr == 8'($past(rp_addr) + 8'd1));

  // R10
  rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_rd |=> rp_addr == 8'($past(rp_addr) + 8'd1));

  // R3
  start_rematch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> state == ST_ADDR);

  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_drive_low);

  // R1
  hi_follow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(kind_hi) == STRAP_SCL) |-> kind_hi == STRAP_SCL);

  // R1
  lo_follow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(kind_lo) == STRAP_SDA) |-> kind_lo == STRAP_SDA);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rp_wr, rp_rd}));

endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_hi       (scl_cur),
  .sda_drive_low(sda_drive_low),
  .start_evt    (start_evt),
  .stop_evt     (stop_evt),
  .rp_wr        (rp_wr),
  .rp_rd        (rp_rd),
  .rp_addr      (rp_addr),
  .state        (eng_state),
  .kind_hi      (kind_hi),
  .kind_lo      (kind_lo)
);

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;

  localparam int QTR = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic [1:0] mode_hi = 2'd0, mode_lo = 2'd0;
  logic       scl, sda, sel_hi, sel_lo;
  logic       sda_drive_low, rp_wr, rp_rd;
  logic [7:0] rp_addr, rp_wdata, rp_rdata;
  logic [7:0] mem [256];
  int         checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign scl = m_scl;
  assign sda = !(m_sda_low || sda_drive_low);

  function automatic logic pick(logic [1:0] m, logic c, logic d);
    case (m)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return c;
      default: return d;
    endcase
  endfunction

  assign sel_hi = pick(mode_hi, scl, sda);
  assign sel_lo = pick(mode_lo, scl, sda);
  assign rp_rdata = mem[rp_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else begin
      if (rp_wr) begin mem[rp_addr] <= rp_wdata; wr_cnt <= wr_cnt + 1; end
      if (rp_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  i2c_strap_target i_i2c_strap_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .sda_drive_low(sda_drive_low), .sel_hi_in(sel_hi), .sel_lo_in(sel_lo),
    .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_wr(rp_wr), .rp_rd(rp_rd),
    .rp_rdata(rp_rdata)
  );

  // write address restated arithmetically: 0xC0 + 2*idx, idx 0 and 12 swapped
  function automatic logic [7:0] exp_waddr(int hi, int lo);
    int idx = hi * 4 + lo;
    if (idx == 0) idx = 12;
    else if (idx == 12) idx = 0;
    return 8'(8'hC0 + 2 * idx);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1;     hold();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b0;     hold();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; hold();
    m_scl = 1'b1;     hold();
    m_sda_low = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; hold();
      m_scl = 1'b1; hold(); hold();
      m_scl = 1'b0; hold();
    end
    m_sda_low = 1'b0; hold();
    m_scl = 1'b1; hold();
    ack = !sda; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic steady);
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = 1'b0; hold();
      m_scl = 1'b1; hold();
      b[i] = sda; hold();
      if (sda != b[i]) steady = 1'b0;
      m_scl = 1'b0; hold();
    end
    m_sda_low = give_ack; hold();
    m_scl = 1'b1; hold(); hold();
    m_scl = 1'b0; hold();
    m_sda_low = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic       ack, steady;
    logic [7:0] b, wa, r, d, wrong;
    int         w0, r0;
    for (int hi = 0; hi < 4; hi++) begin
      for (int lo = 0; lo < 4; lo++) begin
        mode_hi = 2'(hi); mode_lo = 2'(lo);
        do_reset();
        // R11 reset state
        chk(sda && !sda_drive_low && !rp_wr && !rp_rd, "R11 reset idle", sda_drive_low, 0);
        wa = exp_waddr(hi, lo);
        r  = 8'(hi * 16 + lo * 4 + 3);
        d  = 8'h3C ^ 8'(hi * 17 + lo * 5);
        w0 = wr_cnt;
        // write transaction
        bus_start();
        send_byte(wa, ack);
        chk(ack, "R1 R2 address ack", int'(ack), 1);
        send_byte(r, ack);
        chk(ack, "R7 register byte ack", int'(ack), 1);
        send_byte(d, ack);
        chk(ack, "R7 data ack", int'(ack), 1);
        bus_stop();
        chk(mem[r] == d && wr_cnt == w0 + 1, "R7 write landed", int'(mem[r]), int'(d));
        // read back through repeated START
        r0 = rd_cnt;
        bus_start();
        send_byte(wa, ack);
        send_byte(r, ack);
        bus_start();
        send_byte(wa | 8'h01, ack);
        chk(ack, "R6 R3 read address ack", int'(ack), 1);
        recv_byte(1'b0, b, steady);
        chk(b == d && steady, "R8 read data", int'(b), int'(d));
        chk(sda, "R9 released after nack", int'(sda), 1);
        chk(rd_cnt == r0 + 1, "R9 one fetch", rd_cnt - r0, 1);
        bus_stop();
        chk(sda && !sda_drive_low, "R4 idle after stop", int'(sda), 1);
        // neighbour address must be refused
        wrong = exp_waddr(hi, (lo + 1) % 4);
        w0 = wr_cnt;
        bus_start();
        send_byte(wrong, ack);
        chk(!ack, "R5 foreign address nack", int'(ack), 0);
        send_byte(8'hFF, ack);
        bus_stop();
        chk(!ack && wr_cnt == w0 && mem[r] == d, "R5 no effect", wr_cnt - w0, 0);
      end
    end
    // burst with pointer wrap in the last configuration (SDA, SDA)
    wa = exp_waddr(3, 3);
    w0 = wr_cnt;
    bus_start();
    send_byte(wa, ack);
    send_byte(8'hFE, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    bus_stop();
    chk(mem[8'hFE] == 8'h11, "R10 burst byte 0", int'(mem[8'hFE]), 'h11);
    chk(mem[8'hFF] == 8'h22, "R10 burst byte 1", int'(mem[8'hFF]), 'h22);
    chk(mem[8'h00] == 8'h33, "R10 burst wraps", int'(mem[8'h00]), 'h33);
    chk(wr_cnt == w0 + 3, "R7 three strobes", wr_cnt - w0, 3);
    r0 = rd_cnt;
    bus_start();
    send_byte(wa, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(wa | 8'h01, ack);
    recv_byte(1'b1, b, steady);
    chk(b == 8'h11 && steady, "R9 ack continues", int'(b), 'h11);
    recv_byte(1'b1, b, steady);
    chk(b == 8'h22 && steady, "R10 read advance", int'(b), 'h22);
    recv_byte(1'b0, b, steady);
    chk(b == 8'h33 && steady, "R10 read wraps", int'(b), 'h33);
    chk(rd_cnt == r0 + 3 && sda, "R9 nack stops", rd_cnt - r0, 3);
    bus_stop();
    // clocking a byte with no START
    w0 = wr_cnt;
    send_byte(wa, ack);
    chk(!ack && wr_cnt == w0, "R4 no start no ack", int'(ack), 0);
    bus_stop();
    finish_run();
  end

endmodule